// File: doc/BRIEF.md
# Bit-Mask Partition Address Generator

This block produces the global element indices that make up one part of a partitioned array. The caller gives the array size as log2 n, a part number, and a bit mask that marks the index positions that vary inside a part. The block then streams every member address of that part, one address per cycle. Each address is built by scattering two fields across the index. The part number fills the positions where the mask is clear. A running enumeration counter fills the positions where the mask is set. Both fields are consumed from their least significant bit upward, and the index positions are walked from bit 0 upward. Two indices therefore fall in the same part exactly when they match on every position outside the mask.

A part holds 2^k elements, where k is the number of set mask bits. There are 2^(log2 n - k) parts. The part count is reported along with the stream. Addresses leave under a valid/ready handshake, and a last flag marks the final address of the part. A request is taken only while the block is idle. A request with a malformed mask or a part number that does not exist raises a one-cycle error and starts nothing. Fetching and storing the data are left to the surrounding logic.

Top module: `part_addr_gen`

## Requirements
- R1: After reset, req_ready_o is 1, addr_valid_o is 0, addr_last_o is 0, err_o is 0 and num_parts_o is 0.
- R2: Address bit b takes the next unused bit of the enumeration counter when mask bit b is 1. Otherwise it takes the next unused bit of the part number. Both fields are consumed from bit 0 upward as b rises from 0 to L-1. With log2 n = 4 and mask 0110, parts 0..3 yield {0,2,4,6}, {1,3,5,7}, {8,10,12,14} and {9,11,13,15}.
- R3: The first address is valid in the cycle after acceptance. Later addresses follow in increasing counter order, from 0 to 2^k-1, one per handshake.
- R4: addr_last_o is 1 on the 2^k-th address only.
- R5: While addr_valid_o is 1 and addr_ready_i is 0, addr_o and addr_last_o hold and addr_valid_o stays 1.
- R6: From the cycle after acceptance, num_parts_o equals 2^(log2 n - k).
- R7: Some requests are malformed: the mask has no set bit, the mask has a set bit at or above log2 n, or log2 n is outside 1..L. Such a request drives err_o to 1 for exactly the next cycle and produces no address.
- R8: A request whose part number is at or above the part count drives err_o to 1 for the next cycle and produces no address.
- R9: While a part is streaming, req_ready_o is 0. A request presented then is ignored: the stream continues unchanged and err_o stays 0.
- R10: The cycle after the handshake of the last address, addr_valid_o is 0 and req_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Part request strobe |
| req_ready_o | output | 1 | Idle; a request is taken this cycle |
| log_n_i | input | LOGW | log2 of the array size |
| part_i | input | L | Part number |
| mask_i | input | L | Positions enumerated inside the part |
| err_o | output | 1 | Rejected request, one cycle |
| num_parts_o | output | L+1 | Part count of the last accepted request |
| addr_valid_o | output | 1 | addr_o carries a member address |
| addr_ready_i | input | 1 | Consumer takes the address |
| addr_o | output | L | Global element index |
| addr_last_o | output | 1 | Final address of the part |

## Verification
A request taken at a clock edge gives its first address, its part count and any error flag on the outputs right after that edge. The bench drives inputs on the falling edge and samples on the next falling edge. Each later address appears one edge after the handshake that consumed the previous one, so the bench raises ready, lets one rising edge pass, and compares at the following falling edge. Stall cycles, ignored requests and error pulses are each sampled one falling edge after the edge that could have changed them. The idle state is checked one falling edge after the final handshake.

// File: rtl/part_addr_pkg.sv
package part_addr_pkg;

  function automatic int unsigned pop_bits(input logic [63:0] v, input int unsigned w);
    int unsigned n;
    n = 0;
    for (int unsigned b = 0; b < 64; b++)
      if (b < w && v[b]) n++;
    return n;
  endfunction

endpackage

// File: rtl/part_req_check.sv
module part_req_check #(
  parameter int unsigned L    = 8,
  parameter int unsigned LOGW = $clog2(L + 1)
) (
  input  logic [LOGW-1:0] log_n_i,
  input  logic [L-1:0]    part_i,
  input  logic [L-1:0]    mask_i,
  output logic            ok_o,
  output logic [L:0]      num_parts_o,
  output logic [L-1:0]    last_idx_o
);
  import part_addr_pkg::*;

  localparam int unsigned KW = $clog2(L + 1);

  logic [KW-1:0] k;
  logic          shape_ok;
  logic [L-1:0]  high_bits;

  always_comb begin
    k           = KW'(pop_bits(64'(mask_i), L));
    high_bits   = mask_i >> log_n_i;
    shape_ok    = (log_n_i != '0) && (32'(log_n_i) <= L) && (k != '0) && (high_bits == '0);
    num_parts_o = shape_ok ? ((L+1)'(1) << (32'(log_n_i) - 32'(k))) : '0;
    last_idx_o  = L'(((L+1)'(1) << k) - (L+1)'(1));
    ok_o        = shape_ok && ((L+1)'(part_i) < num_parts_o);
  end

endmodule

// File: rtl/part_scatter.sv
module part_scatter #(
  parameter int unsigned L = 8
) (
  input  logic [L-1:0] mask_i,
  input  logic [L-1:0] part_i,
  input  logic [L-1:0] cnt_i,
  output logic [L-1:0] addr_o
);

  // rank of each position among masked / unmasked positions below it
  always_comb begin
    int unsigned ci;
    int unsigned pi;
    ci = 0;
    pi = 0;
    addr_o = '0;
    for (int unsigned b = 0; b < L; b++) begin
      if (mask_i[b]) begin
        addr_o[b] = cnt_i[ci];
        ci++;
      end else begin
        addr_o[b] = part_i[pi];
        pi++;
      end
    end
  end

endmodule

// File: rtl/part_addr_gen.sv
module part_addr_gen #(
  parameter int unsigned L    = 8,
  parameter int unsigned LOGW = $clog2(L + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [LOGW-1:0] log_n_i,
  input  logic [L-1:0]    part_i,
  input  logic [L-1:0]    mask_i,
  output logic            err_o,
  output logic [L:0]      num_parts_o,
  output logic            addr_valid_o,
  input  logic            addr_ready_i,
  output logic [L-1:0]    addr_o,
  output logic            addr_last_o
);

  logic            req_ok;
  logic [L:0]      req_parts;
  logic [L-1:0]    req_last_idx;
  logic            busy_q, err_q;
  logic [L-1:0]    mask_q, part_q, cnt_q, last_idx_q;
  logic [LOGW-1:0] log_n_q;
  logic [L:0]      num_parts_q;
  logic            accept, start, at_last;

  part_req_check #(.L(L), .LOGW(LOGW)) i_check (
    .log_n_i     (log_n_i),
    .part_i      (part_i),
    .mask_i      (mask_i),
    .ok_o        (req_ok),
    .num_parts_o (req_parts),
    .last_idx_o  (req_last_idx)
  );

  part_scatter #(.L(L)) i_scatter (
    .mask_i (mask_q),
    .part_i (part_q),
    .cnt_i  (cnt_q),
    .addr_o (addr_o)
  );

  assign accept  = req_valid_i && !busy_q;
  assign start   = accept && req_ok;
  assign at_last = (cnt_q == last_idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      err_q       <= 1'b0;
      mask_q      <= '0;
      part_q      <= '0;
      cnt_q       <= '0;
      last_idx_q  <= '0;
      log_n_q     <= '0;
      num_parts_q <= '0;
    end else begin
      err_q <= accept && !req_ok;
      if (start) begin
        busy_q      <= 1'b1;
        mask_q      <= mask_i;
        part_q      <= part_i;
        cnt_q       <= '0;
        last_idx_q  <= req_last_idx;
        log_n_q     <= log_n_i;
        num_parts_q <= req_parts;
      end else if (busy_q && addr_ready_i) begin
        if (at_last) busy_q <= 1'b0;
        else         cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign req_ready_o  = !busy_q;
  assign err_o        = err_q;
  assign num_parts_o  = num_parts_q;
  assign addr_valid_o = busy_q;
  assign addr_last_o  = busy_q && at_last;

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o) && $stable(addr_last_o)); // R5
  AST_ERR_NO_STREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !addr_valid_o); // R7
  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> ((addr_o >> log_n_q) == '0)); // R2
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && addr_last_o && addr_ready_i |=> !addr_valid_o && req_ready_o); // R10
  AST_PARTS_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> num_parts_o != '0); // R6
  AST_BUSY_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_last_o |=> !err_o); // R9

endmodule

// File: tb/test_part_addr_gen.sv
module test_part_addr_gen;
  localparam int unsigned L    = 8;
  localparam int unsigned LOGW = $clog2(L + 1);

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [LOGW-1:0] log_n = '0;
  logic [L-1:0]    part = '0;
  logic [L-1:0]    mask = '0;
  logic            err;
  logic [L:0]      num_parts;
  logic            addr_valid;
  logic            addr_ready = 1'b0;
  logic [L-1:0]    addr;
  logic            addr_last;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  part_addr_gen #(.L(L), .LOGW(LOGW)) i_part_addr_gen (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .log_n_i(log_n), .part_i(part), .mask_i(mask), .err_o(err), .num_parts_o(num_parts),
    .addr_valid_o(addr_valid), .addr_ready_i(addr_ready), .addr_o(addr), .addr_last_o(addr_last)
  );

  // {log_n[3:0], mask[7:0], part[7:0], stall}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {4'd4, 8'b0000_0110, 8'd0, 1'b0},
    {4'd4, 8'b0000_0110, 8'd1, 1'b1},
    {4'd4, 8'b0000_0110, 8'd2, 1'b0},
    {4'd4, 8'b0000_0110, 8'd3, 1'b0},
    {4'd8, 8'b1010_0101, 8'd5, 1'b1},
    {4'd3, 8'b0000_0111, 8'd0, 1'b0},
    {4'd8, 8'b1000_0000, 8'd100, 1'b0},
    {4'd5, 8'b0001_0001, 8'd6, 1'b1},
    {4'd8, 8'b1111_1111, 8'd0, 1'b0},
    {4'd1, 8'b0000_0001, 8'd0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // consumes part bits and counter bits from the bottom as positions rise
  function automatic logic [L-1:0] model_addr(input logic [L-1:0] m, input logic [L-1:0] p,
                                              input logic [L-1:0] e);
    logic [L-1:0] pp, ee, a;
    pp = p; ee = e; a = '0;
    for (int b = 0; b < L; b++) begin
      if (m[b]) begin a[b] = ee[0]; ee = ee >> 1; end
      else      begin a[b] = pp[0]; pp = pp >> 1; end
    end
    return a;
  endfunction

  task automatic run_part(input logic [3:0] lg, input logic [L-1:0] m, input logic [L-1:0] p,
                          input bit stall);
    int k;
    int cnt;
    k = $countones(m);
    cnt = 1 << k;
    @(negedge clk);
    log_n = LOGW'(lg); mask = m; part = p; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(addr_valid === 1'b1 && err === 1'b0, "R3 start", addr_valid, 1);
    chk(num_parts === (L+1)'(1 << (lg - k)), "R6 part count", num_parts, 1 << (lg - k));
    for (int i = 0; i < cnt; i++) begin
      if (stall && (i % 3 == 0)) begin
        addr_ready = 1'b0;
        @(negedge clk);
        chk(addr_valid === 1'b1 && addr === model_addr(m, p, L'(i)), "R5 stall hold",
            addr, model_addr(m, p, L'(i)));
      end
      chk(addr === model_addr(m, p, L'(i)), "R2 address", addr, model_addr(m, p, L'(i)));
      chk(addr_last === (i == cnt - 1), "R4 last flag", addr_last, i == cnt - 1);
      addr_ready = 1'b1;
      @(negedge clk);
      addr_ready = 1'b0;
    end
    chk(addr_valid === 1'b0 && req_ready === 1'b1, "R10 idle after last", addr_valid, 0);
  endtask

  task automatic bad_req(input logic [3:0] lg, input logic [L-1:0] m, input logic [L-1:0] p,
                         input string req);
    @(negedge clk);
    log_n = LOGW'(lg); mask = m; part = p; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err === 1'b1 && addr_valid === 1'b0, req, err, 1);
    @(negedge clk);
    chk(err === 1'b0 && addr_valid === 1'b0 && req_ready === 1'b1, req, err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && addr_valid === 1'b0 && addr_last === 1'b0 && err === 1'b0
        && num_parts === '0, "R1 reset state", addr_valid, 0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++)
      run_part(VEC[v][20:17], VEC[v][16:9], VEC[v][8:1], VEC[v][0]);

    // R2 literal example: part 2 of 16 with mask 0110
    @(negedge clk);
    log_n = 4'd4; mask = 8'b0000_0110; part = 8'd2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(addr === L'(8 + 2 * i), "R2 literal", addr, 8 + 2 * i);
      addr_ready = 1'b1;
      @(negedge clk);
      addr_ready = 1'b0;
    end

    // R9: request while streaming is ignored
    @(negedge clk);
    log_n = 4'd4; mask = 8'b0000_1001; part = 8'd3; req_valid = 1'b1;
    @(negedge clk);
    log_n = 4'd4; mask = 8'b0000_0000; part = 8'd0;
    chk(req_ready === 1'b0, "R9 not ready while busy", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(err === 1'b0 && addr === model_addr(8'b0000_1001, 8'd3, 8'd0), "R9 busy request ignored",
        addr, model_addr(8'b0000_1001, 8'd3, 8'd0));
    for (int i = 0; i < 4; i++) begin
      chk(addr === model_addr(8'b0000_1001, 8'd3, L'(i)), "R9 stream unchanged",
          addr, model_addr(8'b0000_1001, 8'd3, L'(i)));
      addr_ready = 1'b1;
      @(negedge clk);
      addr_ready = 1'b0;
    end
    chk(addr_valid === 1'b0, "R9 stream length", addr_valid, 0);

    bad_req(4'd4, 8'b0000_0000, 8'd0, "R7 empty mask");
    bad_req(4'd4, 8'b0001_0010, 8'd0, "R7 mask above log n");
    bad_req(4'd0, 8'b0000_0001, 8'd0, "R7 zero log n");
    bad_req(4'd9, 8'b0000_0001, 8'd0, "R7 log n above L");
    bad_req(4'd4, 8'b0000_0110, 8'd4, "R8 part at count");
    bad_req(4'd8, 8'b1111_1111, 8'd1, "R8 part above count");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule